// File: doc/BRIEF.md
# Eight-Channel Converter Sequencer

The block controls a successive-approximation converter with eight inputs and ten-bit results. Software writes one 32-bit control word over a simple write port. The word picks the input channels, the clock divider and the resolution. It also sets whether conversions are single-shot (started by software or by an external trigger edge) or run as a free-running scan. The analog front end is modelled by one ten-bit digital sample per channel. Conversion time is modelled by counting ticks of the divided converter clock.

A second, read-only word holds the latest result, the channel it came from and a completion flag. A read strobe clears that flag, so software can poll the flag, take the result and strobe the read.

Top module: `convctl`

## Requirements
- R1: The control word keeps only bits 7:0 (channel select), 15:8 (divider), 16 (scan enable), 19:17 (resolution code), 21 (power enable), 26:24 (start code) and 27 (edge polarity). Every other bit reads back as 0. After reset the control word, the data word and the busy flag are all 0.
- R2: A write with start code 001, scan enable 0, power enable 1 and a nonzero select starts one conversion in that same clock cycle, on the lowest set select bit. With start code 000 and scan disabled, no conversion ever begins.
- R3: A conversion lasts (11 - code) × (divider + 1) clock cycles, where code is the resolution code (bits 19:17). The count runs from the starting clock edge to the edge that sets the completion flag.
- R4: The result sits in data bits 15:6 and the channel number in bits 26:24. The result keeps the top (10 - code) bits of the sample, and its low code bits are zero.
- R5: The completion flag is data bit 31. It is set when a conversion ends. It is cleared by the read strobe, or by a conversion started from idle or by software. The result stays after the strobe.
- R6: With start code 100 and scan disabled, a conversion starts on an edge of the trigger input. Edge polarity 0 selects the rising edge and 1 the falling edge. The other edge does nothing.
- R7: With scan enable 1 (start code 000), the block converts the selected channels again and again, in ascending order from the lowest set bit, and wraps around. Moving on to the next channel leaves the completion flag as it is.
- R8: While power enable is 0, no conversion runs. Clearing it stops a conversion in progress at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and converter source clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| gdr_rd | input | 1 | Data word read strobe, clears the completion flag |
| ext_trig | input | 1 | External start trigger |
| samples | input | 80 | Ten-bit digital sample per channel, channel 0 in the low bits |
| ctrl | output | 32 | Current control word |
| gdr | output | 32 | Data word: flag, channel, result |
| busy | output | 1 | A conversion is in progress |

## Verification
The assertions assume that the trigger input changes only at clock-synchronous points. They also assume that a read strobe never lands on the same cycle as a completion. This holds because every conversion is at least four cycles long and the bench strobes for one cycle right after it sees the flag. The bench drives the trigger at falling clock edges. It keeps the divider small in its random phase, so many conversions fit in a short run. It also uses a single-channel software start or the defined start codes, never a scan combined with a nonzero start code.

// File: rtl/convctl.sv
module convctl #(
  parameter int NCH = 8,
  parameter int RW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              gdr_rd,
  input  logic              ext_trig,
  input  logic [NCH*RW-1:0] samples,
  output logic [31:0]       ctrl,
  output logic [31:0]       gdr,
  output logic              busy
);
  localparam int CHW = $clog2(NCH);
  localparam logic [31:0] WMASK = 32'h0F2F_FFFF;

  logic [7:0]     divcnt;
  logic [3:0]     bitcnt;
  logic [CHW-1:0] cur, res_ch;
  logic [RW-1:0]  res_q;
  logic           done_q, trig_q;

  wire [NCH-1:0] sel   = ctrl[NCH-1:0];
  wire [7:0]     div   = ctrl[15:8];
  wire           scan  = ctrl[16];
  wire [2:0]     clks  = ctrl[19:17];
  wire           pdn   = ctrl[21];
  wire [2:0]     start = ctrl[26:24];
  wire           fall  = ctrl[27];

  wire [31:0] ctrl_nxt = wr_en ? (wr_data & WMASK) : ctrl;
  wire trig_edge = fall ? (trig_q & ~ext_trig) : (~trig_q & ext_trig);

  wire soft_go  = wr_en && wr_data[21] && !wr_data[16] &&
                  wr_data[26:24] == 3'b001 && |wr_data[NCH-1:0];
  wire ext_go   = pdn && !scan && start == 3'b100 && trig_edge && !busy && |sel;
  wire scan_go  = pdn && scan && |sel && !busy;

  wire [3:0] nclk   = 4'(RW + 1) - {1'b0, clks};
  wire       tick   = busy && divcnt == div;
  wire       finish = tick && bitcnt == nclk - 4'd1;

  function automatic logic [CHW-1:0] pick(input logic [NCH-1:0] s,
                                          input logic [CHW-1:0] from,
                                          input logic after);
    logic [CHW-1:0] p;
    p = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (s[i]) p = CHW'(i);
    if (after)
      for (int i = NCH - 1; i >= 0; i--)
        if (s[i] && i > int'(from)) p = CHW'(i);
    return p;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl   <= '0;
      busy   <= 1'b0;
      divcnt <= '0;
      bitcnt <= '0;
      cur    <= '0;
      res_ch <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      trig_q <= ext_trig;
      ctrl   <= ctrl_nxt;
      if (gdr_rd) done_q <= 1'b0;
      if (finish) begin
        done_q <= 1'b1;
        res_ch <= cur;
        res_q  <= samples[int'(cur)*RW +: RW] & ({RW{1'b1}} << clks);
      end
      if (!ctrl_nxt[21]) begin
        busy <= 1'b0;
      end else if (soft_go || ext_go || scan_go) begin
        busy   <= 1'b1;
        divcnt <= '0;
        bitcnt <= '0;
        done_q <= 1'b0;
        cur    <= soft_go ? pick(wr_data[NCH-1:0], '0, 1'b0) : pick(sel, '0, 1'b0);
      end else if (finish) begin
        if (scan && |sel) begin
          cur    <= pick(sel, cur, 1'b1);
          divcnt <= '0;
          bitcnt <= '0;
        end else begin
          busy <= 1'b0;
        end
      end else if (tick) begin
        divcnt <= '0;
        bitcnt <= bitcnt + 4'd1;
      end else if (busy) begin
        divcnt <= divcnt + 8'd1;
      end
    end
  end

  always_comb begin
    gdr          = '0;
    gdr[31]      = done_q;
    gdr[26:24]   = 3'(res_ch);
    gdr[15 -: RW] = res_q;
  end
endmodule

module convctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        gdr_rd,
  input logic [31:0] ctrl,
  input logic [31:0] gdr,
  input logic        busy
);
  AST_IDLE_IN_PDN: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[21] |-> !busy); // R8

  AST_DONE_AFTER_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gdr[31]) |-> $past(busy)); // R5

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    gdr_rd && !busy |=> !gdr[31]); // R5

  AST_NO_SELF_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) && !$past(ctrl[16]) |-> $past(wr_en) || $past(ctrl[26:24]) == 3'b100); // R2

  AST_SCAN_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    gdr[31] && ctrl[16] && busy && !gdr_rd && !wr_en |=> gdr[31]); // R7
endmodule

bind convctl convctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .gdr_rd(gdr_rd),
  .ctrl(ctrl), .gdr(gdr), .busy(busy)
);

// File: tb/convctl_bench.sv
module convctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        gdr_rd = 1'b0;
  logic        ext_trig = 1'b0;
  logic [79:0] samples = '0;
  logic [31:0] ctrl, gdr;
  logic        busy;
  int total = 0, bad = 0;

  convctl u_convctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .gdr_rd(gdr_rd),
    .ext_trig(ext_trig), .samples(samples), .ctrl(ctrl), .gdr(gdr), .busy(busy)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mk(input logic [7:0] sel, input logic [7:0] div,
      input logic scan, input logic [2:0] clks, input logic pdn,
      input logic [2:0] st, input logic edg);
    return {4'b0, edg, st, 2'b0, pdn, 1'b0, clks, scan, div, sel};
  endfunction

  function automatic int exp_len(input int div, input int clks);
    return (11 - clks) * (div + 1);
  endfunction

  function automatic logic [9:0] exp_res(input logic [9:0] s, input int clks);
    return (s >> clks) << clks;
  endfunction

  function automatic int lowest(input logic [7:0] s);
    for (int i = 0; i < 8; i++) if (s[i]) return i;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd_pulse();
    @(negedge clk); gdr_rd = 1'b1;
    @(negedge clk); gdr_rd = 1'b0;
  endtask

  task automatic measure(output int k);
    @(posedge clk);
    k = 0;
    do begin
      @(negedge clk);
      wr_en = 1'b0;
      if (gdr[31]) break;
      @(posedge clk);
      k++;
    end while (k < 5000);
  endtask

  task automatic soft_run(input logic [7:0] sel, input int div, input int clks, output int k);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = mk(sel, 8'(div), 1'b0, 3'(clks), 1'b1, 3'b001, 1'b0);
    measure(k);
  endtask

  task automatic idle_check(input int n, input string tag);
    repeat (n) @(negedge clk);
    chk(!busy && !gdr[31], tag, {gdr[31], busy}, 0);
  endtask

  initial begin
    #(8 * 150000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k, ch, div, clks;
    logic [7:0] sel;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ctrl == 0 && gdr == 0 && !busy, "R1 reset", {ctrl[30:0], busy}, 0);

    wr(32'hFFDF_FFFF);
    chk(ctrl == 32'h0F0F_FFFF, "R1 readback mask", ctrl, 32'h0F0F_FFFF);
    idle_check(40, "R8 no conversion while powered down");

    wr(mk(8'h01, 0, 1'b0, 0, 1'b0, 3'b001, 1'b0));
    idle_check(40, "R8 soft start ignored when powered down");

    wr(mk(8'h04, 0, 1'b0, 0, 1'b1, 3'b000, 1'b0));
    idle_check(60, "R2 start code 000 starts nothing");

    samples[50 +: 10] = 10'h2A7;
    soft_run(8'h20, 13, 0, k);
    chk(k == 154, "R3 divide by 14 full length", k, 154);
    chk(gdr[15:6] == 10'h2A7 && gdr[26:24] == 3'd5, "R4 full result", gdr, {5'b0, 3'd5, 8'b0, 10'h2A7, 6'b0});

    samples[0 +: 10] = 10'h3FF;
    soft_run(8'h01, 0, 7, k);
    chk(k == 4, "R3 shortest conversion", k, 4);
    chk(gdr[15:6] == 10'h380, "R4 three-bit alignment", gdr[15:6], 10'h380);

    rd_pulse();
    chk(!gdr[31] && gdr[15:6] == 10'h380, "R5 read clears flag keeps result", gdr, 32'h0000_E000);

    for (int it = 0; it < 24; it++) begin
      for (int i = 0; i < 8; i++) samples[i*10 +: 10] = 10'($urandom);
      sel = 8'($urandom);
      if (sel == 0) sel = 8'h80;
      div = int'($urandom % 5);
      clks = int'($urandom % 8);
      ch = lowest(sel);
      soft_run(sel, div, clks, k);
      chk(k == exp_len(div, clks), "R3 random length", k, exp_len(div, clks));
      chk(gdr[26:24] == 3'(ch), "R2 lowest select bit", gdr[26:24], ch);
      chk(gdr[15:6] == exp_res(samples[ch*10 +: 10], clks), "R4 random result",
          gdr[15:6], exp_res(samples[ch*10 +: 10], clks));
    end
    rd_pulse();

    samples[20 +: 10] = 10'h155;
    wr(mk(8'h04, 1, 1'b0, 2, 1'b1, 3'b100, 1'b0));
    @(negedge clk); ext_trig = 1'b1;
    measure(k);
    chk(k == 18, "R6 rising trigger length", k, 18);
    chk(gdr[15:6] == exp_res(10'h155, 2), "R6 rising trigger result", gdr[15:6], exp_res(10'h155, 2));
    @(negedge clk); ext_trig = 1'b0;
    rd_pulse();
    idle_check(40, "R6 falling edge ignored with polarity 0");

    wr(mk(8'h04, 1, 1'b0, 2, 1'b1, 3'b100, 1'b1));
    @(negedge clk); ext_trig = 1'b1;
    idle_check(40, "R6 rising edge ignored with polarity 1");
    @(negedge clk); ext_trig = 1'b0;
    measure(k);
    chk(k == 18, "R6 falling trigger length", k, 18);
    rd_pulse();

    for (int i = 0; i < 8; i++) samples[i*10 +: 10] = 10'(i * 100 + 7);
    wr(mk(8'h92, 0, 1'b1, 0, 1'b1, 3'b000, 1'b0));
    for (int n = 0; n < 5; n++) begin
      int expch;
      expch = (n % 3 == 0) ? 1 : (n % 3 == 1) ? 4 : 7;
      while (!gdr[31]) @(negedge clk);
      chk(gdr[26:24] == 3'(expch), "R7 scan order", gdr[26:24], expch);
      chk(gdr[15:6] == 10'(expch * 100 + 7), "R7 scan result", gdr[15:6], expch * 100 + 7);
      rd_pulse();
    end

    repeat (3) @(negedge clk);
    wr(mk(8'h92, 0, 1'b1, 0, 1'b0, 3'b000, 1'b0));
    chk(!busy, "R8 power down aborts scan", busy, 0);
    rd_pulse();
    idle_check(40, "R8 scan stays stopped");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule